// File: doc/BRIEF.md
# Four-Edge Pulse Timestamp Sequencer

The block measures a pulse train on one of eight input lines. A select field picks the line, and an optional inversion is applied to it. The line then passes through a two-flop synchronizer and an edge detector. Once software arms the block, it records the current count of one of two external timers at each of four edges, in a fixed order: rising, falling, rising, falling. Each timestamp lands in its own register and raises its own ready bit.

After the fourth timestamp the block disarms itself, so the four values stay frozen until software reads them. Software can abort a sequence at any time. Arming again clears every ready bit and restarts the sequence from the first rising edge. Pulse width and period follow from simple differences of the four stamps.

Top module: `cap4_seq`

## Requirements
- R1: After reset `busy` is 0, `ready` is 4'b0000 and all four stamps are 0.
- R2: `line_sel` (0..7) picks `lines[line_sel]` as the monitored line; changes on the other lines have no effect on stamps or ready bits.
- R3: With `invert` at 1 the selected line is complemented before edge detection, so a high-to-low transition on the pin counts as a rising edge.
- R4: The timestamp is `cnt_a` when `tmr_sel` is 0 and `cnt_b` when it is 1. The value taken is the one present on the clock edge that is the third rising clock edge after the line changes (two synchronizer flops plus one detector flop). Two edges N clocks apart therefore give stamps whose difference equals the count's advance over N clocks.
- R5: While armed, the first rising edge goes to `stamp0`, the next falling edge to `stamp1`, the next rising edge to `stamp2` and the next falling edge to `stamp3`. An edge of the wrong polarity for the current step is ignored, including a falling edge before the first rising edge.
- R6: Each capture into `stampI` sets `ready[I]`. A one on `flag_clr[I]` clears `ready[I]`, but a capture setting the same bit in that same cycle wins. A pulse on `arm` clears all four ready bits.
- R7: On the clock of the fourth capture `busy` returns to 0. While `busy` is 0 no stamp changes.
- R8: A pulse on `disarm` while armed drops `busy` on the next clock and aborts the sequence. Stamps and ready bits already taken are kept, and the next arm starts again at the first rising edge.
- R9: `arm` has priority: when it coincides with `disarm` or with a detected edge, the block ends up armed at step one with `ready` at 0 and takes no stamp that cycle. Arming while already busy restarts the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | One-cycle pulse: arm and clear ready bits |
| disarm | input | 1 | One-cycle pulse: abort the sequence |
| flag_clr | input | 4 | Write-one-to-clear strobes for the ready bits |
| invert | input | 1 | Complement the selected line |
| tmr_sel | input | 1 | Timestamp source: 0 = cnt_a, 1 = cnt_b |
| line_sel | input | 3 | Index of the monitored line |
| lines | input | 8 | Candidate input lines (asynchronous) |
| cnt_a | input | 24 | Count of timer 0 |
| cnt_b | input | 24 | Count of timer 1 |
| busy | output | 1 | Sequence armed and running |
| stamp0 | output | 24 | First rising-edge timestamp |
| stamp1 | output | 24 | First falling-edge timestamp |
| stamp2 | output | 24 | Second rising-edge timestamp |
| stamp3 | output | 24 | Second falling-edge timestamp |
| ready | output | 4 | Per-stamp ready bits, bit I for stampI |

## Verification
Two functions can land on the same clock: the hardware setting of a ready bit by a capture and the software clear of that bit, and likewise an arm pulse and a detected edge. The bench forces each overlap on purpose. It changes the line and then issues `flag_clr` or `arm` exactly two clocks later, so the strobe meets the capture cycle. It then judges the result at the ports: the ready bit must stay set when it collides with a clear, and the ready bits must be all zero with no stamp moving when an edge collides with an arm. A behavioural model compares every output on every clock, including during a long stretch of random toggling, clears and aborts.

// File: rtl/cap4_seq.sv
module cap4_seq #(
  parameter int CW    = 24,
  parameter int NLINE = 8,
  localparam int SW   = $clog2(NLINE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          disarm,
  input  logic [3:0]    flag_clr,
  input  logic          invert,
  input  logic          tmr_sel,
  input  logic [SW-1:0] line_sel,
  input  logic [NLINE-1:0] lines,
  input  logic [CW-1:0] cnt_a,
  input  logic [CW-1:0] cnt_b,
  output logic          busy,
  output logic [CW-1:0] stamp0,
  output logic [CW-1:0] stamp1,
  output logic [CW-1:0] stamp2,
  output logic [CW-1:0] stamp3,
  output logic [3:0]    ready
);

  logic [2:0]    sync;
  logic [1:0]    step;
  logic [CW-1:0] st [4];

  wire          picked = lines[line_sel] ^ invert;
  wire          rise   = sync[1] & ~sync[2];
  wire          fall   = ~sync[1] & sync[2];
  wire          hit    = busy & ~arm & ~disarm & (step[0] ? fall : rise);
  wire [3:0]    hitv   = hit ? (4'b0001 << step) : 4'b0000;
  wire [CW-1:0] now    = tmr_sel ? cnt_b : cnt_a;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync  <= '0;
      step  <= '0;
      busy  <= 1'b0;
      ready <= '0;
      for (int i = 0; i < 4; i++) st[i] <= '0;
    end else begin
      sync <= {sync[1:0], picked};
      if (arm) begin
        busy  <= 1'b1;
        step  <= '0;
        ready <= '0;
      end else begin
        ready <= (ready & ~flag_clr) | hitv;
        if (disarm) begin
          busy <= 1'b0;
          step <= '0;
        end else if (hit) begin
          st[step] <= now;
          step     <= step + 2'd1;
          if (step == 2'd3) busy <= 1'b0;
        end
      end
    end
  end

  assign stamp0 = st[0];
  assign stamp1 = st[1];
  assign stamp2 = st[2];
  assign stamp3 = st[3];

endmodule

module cap4_seq_chk #(
  parameter int CW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          arm,
  input logic          disarm,
  input logic          busy,
  input logic [3:0]    ready,
  input logic [CW-1:0] stamp0,
  input logic [CW-1:0] stamp1,
  input logic [CW-1:0] stamp2,
  input logic [CW-1:0] stamp3
);

  AST_LAST_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready[3]) |-> !busy); // R7
  AST_IDLE_HOLDS_STAMPS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable({stamp0, stamp1, stamp2, stamp3})); // R7
  AST_ARM_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> ready == 4'b0000); // R6
  AST_ABORT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (disarm && !arm) |=> !busy); // R8
  AST_ARM_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> busy); // R9

endmodule

bind cap4_seq cap4_seq_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .disarm(disarm), .busy(busy),
  .ready(ready), .stamp0(stamp0), .stamp1(stamp1), .stamp2(stamp2),
  .stamp3(stamp3)
);

// File: tb/cap4_seq_bench.sv
`timescale 1ns/1ps
module cap4_seq_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        arm = 0, disarm = 0, invert = 0, tmr_sel = 0;
  logic [3:0]  flag_clr = 0;
  logic [2:0]  line_sel = 0;
  logic [7:0]  lines = 0;
  logic [23:0] cnt_a = 0, cnt_b = 0;
  logic        busy;
  logic [23:0] stamp0, stamp1, stamp2, stamp3;
  logic [3:0]  ready;

  int checks = 0, errors = 0;
  bit done = 0;

  cap4_seq u_cap4_seq (.clk(clk), .rst_n(rst_n), .arm(arm), .disarm(disarm),
    .flag_clr(flag_clr), .invert(invert), .tmr_sel(tmr_sel), .line_sel(line_sel),
    .lines(lines), .cnt_a(cnt_a), .cnt_b(cnt_b), .busy(busy), .stamp0(stamp0),
    .stamp1(stamp1), .stamp2(stamp2), .stamp3(stamp3), .ready(ready));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    #1;
    cnt_a <= cnt_a + 24'd1;
    cnt_b <= (cnt_a + 24'd1) * 24'd3 + 24'd7;
  end

  // behavioural reference
  int  m_hist[3];
  bit  m_busy;
  int  m_step;
  bit [3:0]  m_ready;
  bit [23:0] m_st[4];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hist = '{0, 0, 0}; m_busy = 0; m_step = 0; m_ready = 0;
      for (int i = 0; i < 4; i++) m_st[i] = 0;
    end else begin
      bit rose_e, fell_e, want;
      bit [3:0] setv;
      rose_e = (m_hist[1] == 1) && (m_hist[2] == 0);
      fell_e = (m_hist[1] == 0) && (m_hist[2] == 1);
      want = (m_step % 2 == 0) ? rose_e : fell_e;
      setv = 0;
      if (arm) begin
        m_busy = 1; m_step = 0; m_ready = 0;
      end else begin
        if (disarm) begin
          m_busy = 0; m_step = 0;
        end else if (m_busy && want) begin
          m_st[m_step] = tmr_sel ? cnt_b : cnt_a;
          setv[m_step] = 1'b1;
          m_step = m_step + 1;
          if (m_step == 4) begin m_step = 0; m_busy = 0; end
        end
        m_ready = (m_ready & ~flag_clr) | setv;
      end
      m_hist[2] = m_hist[1];
      m_hist[1] = m_hist[0];
      m_hist[0] = lines[line_sel] ^ invert;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R7", "busy", busy, m_busy);
    chk("R6", "ready", ready, m_ready);
    chk("R5", "stamp0", stamp0, m_st[0]);
    chk("R5", "stamp1", stamp1, m_st[1]);
    chk("R5", "stamp2", stamp2, m_st[2]);
    chk("R5", "stamp3", stamp3, m_st[3]);
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_arm();
    arm = 1; tick(1); arm = 0;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] s0, s1, s2, s3;
    tick(3); rst_n = 1; tick(1);
    #1;
    // R1 reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "ready", ready, 0);
    chk("R1", "stamps", {stamp0, stamp1, stamp2, stamp3}, 0);

    // R5 order, early fall ignored; R2 noise on another line
    line_sel = 3; lines[3] = 1; tick(5);
    pulse_arm();
    lines[3] = 0; lines[5] = 1; tick(5);
    lines[3] = 1; lines[5] = 0; tick(4);
    lines[3] = 0; lines[5] = 1; tick(4);
    lines[3] = 1; tick(4);
    lines[3] = 0; lines[5] = 0; tick(6);
    chk("R5", "ready all", ready, 4'hF);
    chk("R7", "busy after fourth", busy, 0);
    chk("R4", "rise-to-fall width cnt_a", stamp1 - stamp0, 4);
    chk("R2", "period from selected line", stamp2 - stamp0, 8);
    s0 = stamp0; s1 = stamp1; s2 = stamp2; s3 = stamp3;
    lines[3] = 1; tick(4); lines[3] = 0; tick(5);
    chk("R7", "idle stamps frozen", {stamp0, stamp1, stamp2, stamp3}, {s0, s1, s2, s3});

    // R3 inversion with R4 timer b
    line_sel = 6; invert = 1; tmr_sel = 1; lines[6] = 1; tick(6);
    pulse_arm();
    lines[6] = 0; tick(4);
    lines[6] = 1; tick(4);
    lines[6] = 0; tick(4);
    lines[6] = 1; tick(6);
    chk("R3", "inverted sequence done", ready, 4'hF);
    chk("R4", "width on cnt_b", stamp1 - stamp0, 12);

    // R8 abort keeps data, restarts
    line_sel = 3; invert = 0; tmr_sel = 0; lines[3] = 0; tick(6);
    pulse_arm();
    lines[3] = 1; tick(4); lines[3] = 0; tick(5);
    chk("R8", "two taken", ready, 4'b0011);
    disarm = 1; tick(1); disarm = 0;
    chk("R8", "busy after abort", busy, 0);
    s0 = stamp0;
    lines[3] = 1; tick(5);
    chk("R8", "no capture after abort", stamp0, s0);
    lines[3] = 0; tick(5);
    pulse_arm();
    lines[3] = 1; tick(5);
    chk("R8", "restart at rise", ready, 4'b0001);

    // R6 clear colliding with capture: set wins
    lines[3] = 0; tick(2);
    flag_clr = 4'b0010; tick(1); flag_clr = 0;
    chk("R6", "set beats clear", ready[1], 1);
    flag_clr = 4'b0001; tick(1); flag_clr = 0;
    chk("R6", "w1c bit0", ready, 4'b0010);

    // R9 arm colliding with an edge, arm with disarm
    lines[3] = 1; tick(2);
    arm = 1; tick(1); arm = 0;
    chk("R9", "edge dropped on arm", ready, 0);
    chk("R9", "armed", busy, 1);
    arm = 1; disarm = 1; tick(1); arm = 0; disarm = 0;
    chk("R9", "arm beats disarm", busy, 1);

    // random
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      lines = (r < 30) ? lines ^ (8'd1 << $urandom_range(0, 7)) : lines;
      arm = (r == 50); disarm = (r == 51);
      flag_clr = (r > 94) ? 4'($urandom) : 4'b0;
      if (r == 52) line_sel = 3'($urandom);
      if (r == 53) invert = ~invert;
      if (r == 54) tmr_sel = ~tmr_sel;
      tick(1);
    end
    arm = 0; disarm = 0; flag_clr = 0;
    tick(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule